// File: doc/BRIEF.md
# Scoreboard Wakeup Issue Queue

This block holds renamed instructions until their source operands are available, then offers each one on a ready vector for its execution class. It keeps one ready bit for every physical register in the combined integer and floating-point pool. On insertion, each source is looked up against that scoreboard. A source that is already available does not make the entry wait. A source that is still pending is compared against every completion broadcast until its producer finishes. Tags at or above the physical register count name special or control registers. Those tags are never tracked.

Instructions are allocated to the lowest free slot of a fixed array. An issue stage picks among the per-class ready vectors and names the chosen slot on the issue port, which frees the slot. A squash by sequence number removes every held entry younger than the given number. A non-speculative instruction waits for an explicit schedule command carrying its sequence number, whatever the state of its sources. A free-entry count and a full flag let the rename stage throttle insertion.

Top module: `opq_issue_queue`

## Requirements
- R1: After reset the queue is empty: `free_cnt` equals ENTRIES, `full` is 0, `alloc_slot` is 0, every ready vector is 0, and every scoreboard bit is clear, so a consumer of any tag below PREGS inserted before any completion waits.
- R2: An accepted insert occupies the lowest-numbered free slot, which `alloc_slot` shows beforehand. `free_cnt` always equals ENTRIES minus the number of occupied slots, and `full` is 1 exactly when `free_cnt` is 0.
- R3: An insert presented while `full` is 1 is dropped: no slot changes and `free_cnt` stays 0.
- R4: At insert a source counts as ready when any of these holds: its pre-ready flag is set; its tag is at or above PREGS; its scoreboard bit is set; or a completion broadcast of the same tag arrives in the same cycle.
- R5: An accepted insert with `ins_dst_vld` set and a destination tag below PREGS clears that tag's scoreboard bit, so a later consumer of it waits. A destination tag at or above PREGS changes nothing.
- R6: A completion broadcast marks every pending source with that tag ready from the next cycle on, and sets the tag's scoreboard bit, so consumers inserted afterwards do not wait.
- R7: A slot whose sources are all ready appears on exactly one ready vector, chosen from `ins_kind` by priority: bit 0 (control) to `rdy_ctrl`, else bit 1 (memory) to `rdy_mem`, else bit 2 (integer) to `rdy_int`, else bit 3 (floating point) to `rdy_fp`, else `rdy_misc`.
- R8: An issue naming a slot that is currently ready frees that slot in the next cycle. An issue naming a slot that is not ready is ignored.
- R9: A squash with number S removes every occupied slot whose sequence number is greater than S, compared unsigned, and frees one slot per removed entry. Older entries are kept.
- R10: An entry inserted with `ins_nonspec` set ignores its source tags. It reaches its ready vector only from the cycle after a schedule command whose sequence number matches its own.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| ins_valid | input | 1 | Insert request |
| ins_seq | input | SEQ_W | Sequence number of the inserted instruction |
| ins_kind | input | 4 | Class flags: bit0 control, bit1 memory, bit2 integer, bit3 floating point |
| ins_nonspec | input | 1 | Instruction waits for a schedule command |
| ins_src_tag | input | NSRC*TAG_W | Source tags, source k in bits k*TAG_W upward |
| ins_src_rdy | input | NSRC | Per-source flag meaning the source is already known ready |
| ins_dst_tag | input | TAG_W | Destination tag |
| ins_dst_vld | input | 1 | Instruction writes a destination |
| cmp_valid | input | 1 | Completion broadcast |
| cmp_tag | input | TAG_W | Tag of the completed destination |
| sq_valid | input | 1 | Squash request |
| sq_seq | input | SEQ_W | Entries with a larger sequence number are removed |
| sch_valid | input | 1 | Schedule command for a non-speculative entry |
| sch_seq | input | SEQ_W | Sequence number being scheduled |
| iss_valid | input | 1 | Issue request |
| iss_slot | input | IDX_W | Slot being issued |
| rdy_ctrl | output | ENTRIES | Ready control-class slots |
| rdy_mem | output | ENTRIES | Ready memory-class slots |
| rdy_int | output | ENTRIES | Ready integer-class slots |
| rdy_fp | output | ENTRIES | Ready floating-point-class slots |
| rdy_misc | output | ENTRIES | Ready slots of any other class |
| alloc_slot | output | IDX_W | Slot the next accepted insert will occupy |
| free_cnt | output | CNT_W | Number of free slots |
| full | output | 1 | No free slot remains |

## Verification
The bench uses the default sizes: eight slots, eight integer plus eight floating-point physical registers, and 5-bit tags. With eight slots, a few inserts fill the queue, so the dropped-insert path and the squash accounting around a full array come up often. Drawing tags from 0 to 19 puts roughly one source in five in the untracked special range above register 15. That mixes untracked operands with scoreboard hits, same-cycle bypasses and producers that re-clear bits. An 8-bit sequence number leaves room to place squash points between live entries.

// File: rtl/opq_pkg.sv
package opq_pkg;

  localparam int KIND_W = 4;

  typedef enum logic [2:0] {
    CLS_CTRL = 3'd0,
    CLS_MEM  = 3'd1,
    CLS_INT  = 3'd2,
    CLS_FP   = 3'd3,
    CLS_MISC = 3'd4
  } opq_cls_e;

  // Priority steering of class flags to a single ready list
  function automatic opq_cls_e opq_steer(input logic [KIND_W-1:0] kind);
    if (kind[0])      return CLS_CTRL;
    else if (kind[1]) return CLS_MEM;
    else if (kind[2]) return CLS_INT;
    else if (kind[3]) return CLS_FP;
    else              return CLS_MISC;
  endfunction

endpackage

// File: rtl/opq_pick.sv
module opq_pick #(
  parameter int N     = 8,
  parameter int IDX_W = 3
) (
  input  logic [N-1:0]     req,
  output logic [IDX_W-1:0] idx
);
  // Lowest set bit wins; idx stays 0 when nothing is requested
  always_comb begin
    idx = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req[i]) idx = IDX_W'(i);
    end
  end
endmodule

// File: rtl/opq_scoreboard.sv
module opq_scoreboard #(
  parameter int PREGS = 16,
  parameter int TAG_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             set_en,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             clr_en,
  input  logic [TAG_W-1:0] clr_tag,
  output logic [PREGS-1:0] rdy_q
);
  logic [PREGS-1:0] rdy_d;
  logic             upd_en;

  assign upd_en = set_en | clr_en;

  // Tags at or above PREGS match no bit; a clear from a new producer wins
  always_comb begin
    rdy_d = rdy_q;
    for (int p = 0; p < PREGS; p++) begin
      if (set_en && set_tag == TAG_W'(p)) rdy_d[p] = 1'b1;
      if (clr_en && clr_tag == TAG_W'(p)) rdy_d[p] = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rdy_q <= '0;
    end else if (upd_en) begin
      rdy_q <= rdy_d;
    end
  end
endmodule

// File: rtl/opq_slot.sv
module opq_slot
  import opq_pkg::*;
#(
  parameter int SEQ_W = 8,
  parameter int TAG_W = 5,
  parameter int NSRC  = 2
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  load,
  input  logic [SEQ_W-1:0]      ld_seq,
  input  opq_cls_e              ld_cls,
  input  logic [NSRC*TAG_W-1:0] ld_tags,
  input  logic [NSRC-1:0]       ld_rdy,
  input  logic                  ld_ns,
  input  logic                  cmp_valid,
  input  logic [TAG_W-1:0]      cmp_tag,
  input  logic                  sq_valid,
  input  logic [SEQ_W-1:0]      sq_seq,
  input  logic                  sch_valid,
  input  logic [SEQ_W-1:0]      sch_seq,
  input  logic                  issue,
  output logic                  valid_o,
  output logic                  ready_o,
  output opq_cls_e              cls_o
);
  logic                  v_q, v_d;
  logic [SEQ_W-1:0]      seq_q;
  opq_cls_e              cls_q;
  logic [NSRC*TAG_W-1:0] tags_q;
  logic [NSRC-1:0]       rdy_q, rdy_d, wake;
  logic                  ns_q, ns_d;
  logic                  kill, sched_hit;

  assign kill      = v_q && sq_valid && (seq_q > sq_seq);
  assign sched_hit = v_q && sch_valid && (sch_seq == seq_q);

  always_comb begin
    for (int k = 0; k < NSRC; k++) begin
      wake[k] = cmp_valid && (tags_q[k*TAG_W +: TAG_W] == cmp_tag);
    end
    if (load) begin
      v_d   = 1'b1;
      rdy_d = ld_rdy;
      ns_d  = ld_ns;
    end else begin
      v_d   = v_q && !kill && !issue;
      rdy_d = rdy_q | wake;
      ns_d  = ns_q && !sched_hit;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      v_q   <= 1'b0;
      rdy_q <= '0;
      ns_q  <= 1'b0;
    end else begin
      v_q   <= v_d;
      rdy_q <= rdy_d;
      ns_q  <= ns_d;
    end
  end

  // Payload needs no reset: it is only observed while v_q is set
  always_ff @(posedge clk) begin
    if (load) begin
      seq_q  <= ld_seq;
      cls_q  <= ld_cls;
      tags_q <= ld_tags;
    end
  end

  assign valid_o = v_q;
  assign ready_o = v_q && (&rdy_q) && !ns_q;
  assign cls_o   = cls_q;
endmodule

// File: rtl/opq_issue_queue.sv
module opq_issue_queue
  import opq_pkg::*;
#(
  parameter int ENTRIES   = 8,
  parameter int INT_PREGS = 8,
  parameter int FP_PREGS  = 8,
  parameter int TAG_W     = 5,
  parameter int SEQ_W     = 8,
  parameter int NSRC      = 2,
  localparam int PREGS    = INT_PREGS + FP_PREGS,
  localparam int IDX_W    = (ENTRIES > 1) ? $clog2(ENTRIES) : 1,
  localparam int CNT_W    = $clog2(ENTRIES + 1)
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  ins_valid,
  input  logic [SEQ_W-1:0]      ins_seq,
  input  logic [KIND_W-1:0]     ins_kind,
  input  logic                  ins_nonspec,
  input  logic [NSRC*TAG_W-1:0] ins_src_tag,
  input  logic [NSRC-1:0]       ins_src_rdy,
  input  logic [TAG_W-1:0]      ins_dst_tag,
  input  logic                  ins_dst_vld,
  input  logic                  cmp_valid,
  input  logic [TAG_W-1:0]      cmp_tag,
  input  logic                  sq_valid,
  input  logic [SEQ_W-1:0]      sq_seq,
  input  logic                  sch_valid,
  input  logic [SEQ_W-1:0]      sch_seq,
  input  logic                  iss_valid,
  input  logic [IDX_W-1:0]      iss_slot,
  output logic [ENTRIES-1:0]    rdy_ctrl,
  output logic [ENTRIES-1:0]    rdy_mem,
  output logic [ENTRIES-1:0]    rdy_int,
  output logic [ENTRIES-1:0]    rdy_fp,
  output logic [ENTRIES-1:0]    rdy_misc,
  output logic [IDX_W-1:0]      alloc_slot,
  output logic [CNT_W-1:0]      free_cnt,
  output logic                  full
);
  localparam logic [TAG_W:0] PREG_LIM = (TAG_W + 1)'(PREGS);

  logic [ENTRIES-1:0] slot_v, slot_rdy, slot_load, iss_hit;
  opq_cls_e           slot_cls [ENTRIES];
  logic [PREGS-1:0]   sb_rdy;
  logic [NSRC-1:0]    ld_rdy;
  logic               accept;
  opq_cls_e           ins_cls;
  logic [CNT_W-1:0]   occ;

  assign full    = &slot_v;
  assign accept  = ins_valid && !full;
  assign ins_cls = opq_steer(ins_kind);

  opq_pick #(.N(ENTRIES), .IDX_W(IDX_W)) u_pick (
    .req (~slot_v),
    .idx (alloc_slot)
  );

  opq_scoreboard #(.PREGS(PREGS), .TAG_W(TAG_W)) u_sb (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_en  (cmp_valid),
    .set_tag (cmp_tag),
    .clr_en  (accept && ins_dst_vld),
    .clr_tag (ins_dst_tag),
    .rdy_q   (sb_rdy)
  );

  // Source readiness at insert: flag, untracked tag, scoreboard, or bypass
  always_comb begin
    logic [TAG_W-1:0] t;
    logic             hit;
    for (int k = 0; k < NSRC; k++) begin
      t   = ins_src_tag[k*TAG_W +: TAG_W];
      hit = 1'b0;
      for (int p = 0; p < PREGS; p++) begin
        if (t == TAG_W'(p)) hit = sb_rdy[p];
      end
      ld_rdy[k] = ins_nonspec | ins_src_rdy[k] | hit
                | ({1'b0, t} >= PREG_LIM)
                | (cmp_valid && (cmp_tag == t));
    end
  end

  for (genvar i = 0; i < ENTRIES; i++) begin : g_slot
    assign slot_load[i] = accept && (alloc_slot == IDX_W'(i));
    assign iss_hit[i]   = iss_valid && (iss_slot == IDX_W'(i)) && slot_rdy[i];

    opq_slot #(.SEQ_W(SEQ_W), .TAG_W(TAG_W), .NSRC(NSRC)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .load      (slot_load[i]),
      .ld_seq    (ins_seq),
      .ld_cls    (ins_cls),
      .ld_tags   (ins_src_tag),
      .ld_rdy    (ld_rdy),
      .ld_ns     (ins_nonspec),
      .cmp_valid (cmp_valid),
      .cmp_tag   (cmp_tag),
      .sq_valid  (sq_valid),
      .sq_seq    (sq_seq),
      .sch_valid (sch_valid),
      .sch_seq   (sch_seq),
      .issue     (iss_hit[i]),
      .valid_o   (slot_v[i]),
      .ready_o   (slot_rdy[i]),
      .cls_o     (slot_cls[i])
    );

    assign rdy_ctrl[i] = slot_rdy[i] && (slot_cls[i] == CLS_CTRL);
    assign rdy_mem[i]  = slot_rdy[i] && (slot_cls[i] == CLS_MEM);
    assign rdy_int[i]  = slot_rdy[i] && (slot_cls[i] == CLS_INT);
    assign rdy_fp[i]   = slot_rdy[i] && (slot_cls[i] == CLS_FP);
    assign rdy_misc[i] = slot_rdy[i] && (slot_cls[i] == CLS_MISC);
  end

  always_comb begin
    occ = '0;
    for (int i = 0; i < ENTRIES; i++) occ = occ + CNT_W'(slot_v[i]);
  end
  assign free_cnt = CNT_W'(ENTRIES) - occ;
endmodule

// File: rtl/opq_issue_queue_chk.sv
module opq_issue_queue_chk #(
  parameter int ENTRIES = 8,
  parameter int IDX_W   = 3,
  parameter int CNT_W   = 4
) (
  input logic               clk,
  input logic               rst_n,
  input logic               ins_valid,
  input logic               sq_valid,
  input logic               iss_valid,
  input logic [IDX_W-1:0]   iss_slot,
  input logic [ENTRIES-1:0] rdy_ctrl,
  input logic [ENTRIES-1:0] rdy_mem,
  input logic [ENTRIES-1:0] rdy_int,
  input logic [ENTRIES-1:0] rdy_fp,
  input logic [ENTRIES-1:0] rdy_misc,
  input logic [CNT_W-1:0]   free_cnt,
  input logic               full
);
  logic [ENTRIES-1:0] any_rdy;
  logic               tgt_rdy;

  assign any_rdy = rdy_ctrl | rdy_mem | rdy_int | rdy_fp | rdy_misc;
  assign tgt_rdy = any_rdy[iss_slot];

  AST_FULL_FREE: assert property (@(posedge clk) disable iff (!rst_n)
    full == (free_cnt == '0)); // R2

  AST_FREE_BOUND: assert property (@(posedge clk) disable iff (!rst_n)
    free_cnt <= CNT_W'(ENTRIES)); // R2

  AST_INSERT_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
    (ins_valid && !full && !iss_valid && !sq_valid)
      |=> free_cnt == $past(free_cnt) - CNT_W'(1)); // R2

  AST_FULL_DROPS: assert property (@(posedge clk) disable iff (!rst_n)
    (full && ins_valid && !iss_valid && !sq_valid) |=> full); // R3

  AST_ISSUE_FREES: assert property (@(posedge clk) disable iff (!rst_n)
    (iss_valid && tgt_rdy && !ins_valid && !sq_valid)
      |=> free_cnt == $past(free_cnt) + CNT_W'(1)); // R8

  for (genvar i = 0; i < ENTRIES; i++) begin : g_one
    AST_ONE_CLASS: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({rdy_ctrl[i], rdy_mem[i], rdy_int[i], rdy_fp[i], rdy_misc[i]})); // R7
  end
endmodule

bind opq_issue_queue opq_issue_queue_chk #(
  .ENTRIES (ENTRIES),
  .IDX_W   (IDX_W),
  .CNT_W   (CNT_W)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .ins_valid (ins_valid),
  .sq_valid  (sq_valid),
  .iss_valid (iss_valid),
  .iss_slot  (iss_slot),
  .rdy_ctrl  (rdy_ctrl),
  .rdy_mem   (rdy_mem),
  .rdy_int   (rdy_int),
  .rdy_fp    (rdy_fp),
  .rdy_misc  (rdy_misc),
  .free_cnt  (free_cnt),
  .full      (full)
);

// File: tb/opq_issue_queue_tb.sv
`timescale 1ns/1ps
module opq_issue_queue_tb;
  localparam int ENT = 8;
  localparam int PR  = 16;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  always #2 clk = ~clk;

  logic        ins_valid = 0, ins_nonspec = 0, ins_dst_vld = 0;
  logic [7:0]  ins_seq = 0, sq_seq = 0, sch_seq = 0;
  logic [3:0]  ins_kind = 0;
  logic [9:0]  ins_src_tag = 0;
  logic [1:0]  ins_src_rdy = 0;
  logic [4:0]  ins_dst_tag = 0, cmp_tag = 0;
  logic        cmp_valid = 0, sq_valid = 0, sch_valid = 0, iss_valid = 0;
  logic [2:0]  iss_slot = 0;
  logic [ENT-1:0] rdy_ctrl, rdy_mem, rdy_int, rdy_fp, rdy_misc;
  logic [2:0]  alloc_slot;
  logic [3:0]  free_cnt;
  logic        full;

  opq_issue_queue #(.ENTRIES(ENT), .INT_PREGS(8), .FP_PREGS(8), .TAG_W(5),
                    .SEQ_W(8), .NSRC(2)) u_dut (.*);

  int total = 0, bad = 0;
  bit done = 0;

  // Reference state
  logic       m_v   [ENT];
  logic [7:0] m_seq [ENT];
  int         m_cls [ENT];
  logic [4:0] m_tag [ENT][2];
  logic       m_r   [ENT][2];
  logic       m_ns  [ENT];
  logic       m_sb  [PR];

  function automatic int steer_m(logic [3:0] k);
    if (k[0]) return 0;
    if (k[1]) return 1;
    if (k[2]) return 2;
    if (k[3]) return 3;
    return 4;
  endfunction

  function automatic logic m_ready(int i);
    return m_v[i] && m_r[i][0] && m_r[i][1] && !m_ns[i];
  endfunction

  task automatic check(string req, string what, int got, int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s %s got=%0h exp=%0h", req, what, got, exp);
    end
  endtask

  task automatic model_reset();
    for (int i = 0; i < ENT; i++) begin
      m_v[i] = 0; m_r[i][0] = 0; m_r[i][1] = 0; m_ns[i] = 0;
    end
    for (int p = 0; p < PR; p++) m_sb[p] = 0;
  endtask

  task automatic model_step();
    logic pr [ENT];
    logic psb [PR];
    logic pfull;
    int   slot;
    pfull = 1; slot = -1;
    for (int i = 0; i < ENT; i++) begin
      pr[i] = m_ready(i);
      if (!m_v[i]) begin
        pfull = 0;
        if (slot < 0) slot = i;
      end
    end
    for (int p = 0; p < PR; p++) psb[p] = m_sb[p];
    for (int i = 0; i < ENT; i++) begin
      if (m_v[i]) begin
        if (sch_valid && sch_seq == m_seq[i]) m_ns[i] = 0;
        for (int k = 0; k < 2; k++)
          if (cmp_valid && cmp_tag == m_tag[i][k]) m_r[i][k] = 1;
        if (sq_valid && m_seq[i] > sq_seq) m_v[i] = 0;
        if (iss_valid && int'(iss_slot) == i && pr[i]) m_v[i] = 0;
      end
    end
    if (cmp_valid && cmp_tag < PR) m_sb[cmp_tag] = 1;
    if (ins_valid && !pfull) begin
      if (ins_dst_vld && ins_dst_tag < PR) m_sb[ins_dst_tag] = 0;
      m_v[slot] = 1; m_seq[slot] = ins_seq; m_cls[slot] = steer_m(ins_kind);
      m_ns[slot] = ins_nonspec;
      for (int k = 0; k < 2; k++) begin
        logic [4:0] t;
        t = ins_src_tag[k*5 +: 5];
        m_tag[slot][k] = t;
        m_r[slot][k] = ins_nonspec || ins_src_rdy[k] || t >= PR ||
                       (t < PR && psb[t]) || (cmp_valid && cmp_tag == t);
      end
    end
  endtask

  task automatic compare(string req);
    logic [ENT-1:0] e [5];
    int nf, lo;
    nf = 0; lo = -1;
    for (int c = 0; c < 5; c++) e[c] = '0;
    for (int i = 0; i < ENT; i++) begin
      if (!m_v[i]) begin nf++; if (lo < 0) lo = i; end
      if (m_ready(i)) e[m_cls[i]][i] = 1'b1;
    end
    if (lo < 0) lo = 0;
    check(req, "free_cnt", free_cnt, nf);
    check(req, "full", full, nf == 0);
    check(req, "alloc_slot", alloc_slot, lo);
    check(req, "rdy_ctrl", rdy_ctrl, e[0]);
    check(req, "rdy_mem", rdy_mem, e[1]);
    check(req, "rdy_int", rdy_int, e[2]);
    check(req, "rdy_fp", rdy_fp, e[3]);
    check(req, "rdy_misc", rdy_misc, e[4]);
  endtask

  task automatic idle();
    ins_valid = 0; cmp_valid = 0; sq_valid = 0; sch_valid = 0; iss_valid = 0;
    ins_nonspec = 0; ins_dst_vld = 0; ins_src_rdy = 0;
  endtask

  task automatic tick(string req);
    @(posedge clk);
    model_step();
    @(negedge clk);
    compare(req);
    idle();
  endtask

  task automatic ins(logic [7:0] s, logic [3:0] k, logic [4:0] t0, logic [4:0] t1,
                     logic [1:0] p, logic [4:0] d, logic dv, logic ns);
    ins_valid = 1; ins_seq = s; ins_kind = k; ins_src_tag = {t1, t0};
    ins_src_rdy = p; ins_dst_tag = d; ins_dst_vld = dv; ins_nonspec = ns;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      bad++; total++;
      $display("FAIL watchdog expired");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5eed));
    model_reset();
    idle();
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    compare("R1");
    // R1: scoreboard starts clear, consumer of tag 3 waits
    ins(8'd1, 4'b0100, 5'd3, 5'd18, 2'b00, 5'd0, 0, 0); tick("R1");
    check("R1", "rdy_int waiting", rdy_int, 0);
    // R4: untracked tags, pre-ready flags, same-cycle bypass
    ins(8'd2, 4'b0100, 5'd18, 5'd19, 2'b00, 5'd0, 0, 0); tick("R4");
    ins(8'd3, 4'b0100, 5'd6, 5'd7, 2'b11, 5'd0, 0, 0);   tick("R4");
    ins(8'd4, 4'b0100, 5'd5, 5'd18, 2'b00, 5'd0, 0, 0);
    cmp_valid = 1; cmp_tag = 5'd5;                        tick("R4");
    check("R4", "bypass slot3", rdy_int[3], 1);
    // R6: completion wakes waiter and sets scoreboard
    cmp_valid = 1; cmp_tag = 5'd3;                        tick("R6");
    ins(8'd5, 4'b0100, 5'd3, 5'd3, 2'b00, 5'd0, 0, 0);   tick("R6");
    // R5: new producer clears the bit again
    ins(8'd6, 4'b0000, 5'd18, 5'd18, 2'b00, 5'd3, 1, 0); tick("R5");
    ins(8'd7, 4'b0100, 5'd3, 5'd18, 2'b00, 5'd0, 0, 0);  tick("R5");
    check("R5", "slot6 waits", rdy_int[6], 0);
    cmp_valid = 1; cmp_tag = 5'd3;                        tick("R6");
    // R8: drain by issue
    for (int i = 0; i < 7; i++) begin
      iss_valid = 1; iss_slot = 3'(i); tick("R8");
    end
    check("R8", "drained", free_cnt, 8);
    // R7: class steering priority
    ins(8'd10, 4'b1111, 5'd20, 5'd20, 2'b00, 5'd0, 0, 0); tick("R7");
    ins(8'd11, 4'b0110, 5'd20, 5'd20, 2'b00, 5'd0, 0, 0); tick("R7");
    ins(8'd12, 4'b1100, 5'd20, 5'd20, 2'b00, 5'd0, 0, 0); tick("R7");
    ins(8'd13, 4'b1000, 5'd20, 5'd20, 2'b00, 5'd0, 0, 0); tick("R7");
    ins(8'd14, 4'b0000, 5'd20, 5'd20, 2'b00, 5'd0, 0, 0); tick("R7");
    check("R7", "rdy_ctrl", rdy_ctrl, 8'h01);
    check("R7", "rdy_fp", rdy_fp, 8'h08);
    // R10: non-speculative waits for its schedule command
    ins(8'd20, 4'b0100, 5'd2, 5'd2, 2'b00, 5'd0, 0, 1);   tick("R10");
    iss_valid = 1; iss_slot = 3'd5;                        tick("R8");
    check("R8", "ignored issue", free_cnt, 2);
    sch_valid = 1; sch_seq = 8'd21;                        tick("R10");
    sch_valid = 1; sch_seq = 8'd20;                        tick("R10");
    check("R10", "scheduled", rdy_int[5], 1);
    // R2/R3: fill, then insert while full
    ins(8'd30, 4'b0100, 5'd20, 5'd20, 2'b00, 5'd0, 0, 0); tick("R2");
    ins(8'd31, 4'b0100, 5'd20, 5'd20, 2'b00, 5'd0, 0, 0); tick("R2");
    check("R2", "full", full, 1);
    ins(8'd32, 4'b0001, 5'd20, 5'd20, 2'b00, 5'd0, 0, 0); tick("R3");
    check("R3", "still full", free_cnt, 0);
    // R9: squash younger than 12
    sq_valid = 1; sq_seq = 8'd12;                          tick("R9");
    check("R9", "free after squash", free_cnt, 5);
    // Random mix
    for (int n = 0; n < 600; n++) begin
      if ($urandom_range(0, 1) == 1)
        ins(8'($urandom_range(0, 255)), 4'($urandom_range(0, 15)),
            5'($urandom_range(0, 19)), 5'($urandom_range(0, 19)),
            2'($urandom_range(0, 3) == 0 ? 1 : 0), 5'($urandom_range(0, 19)),
            1'($urandom_range(0, 1)), 1'($urandom_range(0, 9) == 0));
      if ($urandom_range(0, 2) == 0) begin
        cmp_valid = 1; cmp_tag = 5'($urandom_range(0, 19));
      end
      if ($urandom_range(0, 1) == 1) begin
        iss_valid = 1; iss_slot = 3'($urandom_range(0, 7));
      end
      if ($urandom_range(0, 24) == 0) begin
        sq_valid = 1; sq_seq = 8'($urandom_range(0, 255));
      end
      if ($urandom_range(0, 5) == 0) begin
        sch_valid = 1; sch_seq = 8'($urandom_range(0, 255));
      end
      tick("R2");
    end
    done = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule